// File: doc/BRIEF.md
# Paired-Clock Multi-Channel PWM Controller

This block generates several pulse-width-modulated outputs from two free-running clock-enable strobes, one from an oscillator domain and one from a bus domain. Neighbouring channels are grouped in pairs. Each pair picks one of the two strobes and divides it by a power of two. Every channel then divides the pair's strobe again by its own 8-bit prescaler and drives a 16-bit period counter. The active phase of the output lasts while the counter is below a programmed active count, and a polarity bit sets which level the active phase drives.

Software programs the block through a single-cycle register write port and a combinational read port. A channel produces a waveform only when both its clock gate bit and its enable bit are set. Otherwise its pad is released to high impedance. A write to a channel's control or period register takes effect on the same clock edge: the channel's counters restart from zero with the new values, and the period in progress is not completed.

Top module: `pwm_pair_ctrl`

## Requirements
- R1: Reset is asynchronous and active low. It clears every register, so all registers read 0 and every `pwm_oe` bit is 0.
- R2: A read returns the last word written to the same address. The addresses are: 0x20+4n for the clock configuration of pair n, 0x40 for gate (bit c gates channel c, bits 16+c are stored bypass bits), 0x80 for enable (bit c), 0x100+0x20c for control of channel c, and 0x104+0x20c for period of channel c.
- R3: Channel c runs and raises `pwm_oe[c]` only while gate bit c and enable bit c are both 1. Otherwise `pwm_oe[c]` is 0 and `pwm_pad[c]` is high impedance. While the output is enabled, `pwm_pad[c]` equals `pwm_lvl[c]`.
- R4: Clock configuration bits 8:7 choose the source: 0 selects `osc_tick`, any other value selects `bus_tick`. Bits 3:0 give the exponent M. Control bits 7:0 give K. Period bits 31:16 give E and bits 15:0 give A. One output period lasts (E+1)·(K+1)·2^M source ticks, and the active phase lasts A·(K+1)·2^M source ticks.
- R5: Control bit 8 sets polarity: 1 drives the active phase high, 0 drives it low.
- R6: When A is greater than E the output stays constantly active, and A = E+1 also gives 100 %. When A = 0 the output stays constantly inactive.
- R7: Exponent values above 8 behave as 8.
- R8: Channels 2n and 2n+1 both take their source and exponent from the pair register at 0x20+4n.
- R9: A write to a channel's control or period register clears that channel's counters on the writing edge. The next cycle starts a fresh period with the new settings.
- R10: The period counter steps from 0 to E and then wraps to 0. The prescaler counts from 0 to K and steps the period counter when it wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_tick | input | 1 | Oscillator-domain clock enable strobe |
| bus_tick | input | 1 | Bus-domain clock enable strobe |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Register byte address for reads and writes |
| wdata | input | 32 | Register write data |
| rdata | output | 32 | Read data for `addr` |
| pwm_lvl | output | NCH | Per-channel waveform level before the pad driver |
| pwm_oe | output | NCH | Per-channel output enable |
| pwm_pad | output | NCH | Tri-stated per-channel output |

## Verification
A corrupted counter or prescaler shows up at the pins within one output period, as a wrong count of active cycles or of rising edges over a window spanning whole periods. A restart that is missing or late appears in the first cycle after the write, because the active phase must begin at once. A wrong decode of the pair register or of the exponent stretches or shrinks the measured period by a factor of two or more, and a channel that starts without both permissions raises its enable in the cycle after the offending write.

// File: rtl/pwm_pair_pkg.sv
`timescale 1ns/1ps
package pwm_pair_pkg;
  localparam int CNT_W      = 16;
  localparam int PRE_W      = 8;
  localparam int EXP_W      = 4;
  localparam int MAX_EXP    = 8;
  localparam int DIV_W      = MAX_EXP;
  localparam int REG_W      = 32;

  // register map (byte addresses)
  localparam int CFG_BASE   = 'h020;
  localparam int CFG_STRIDE = 'h004;
  localparam int GATE_ADDR  = 'h040;
  localparam int EN_ADDR    = 'h080;
  localparam int CTL_BASE   = 'h100;
  localparam int PER_BASE   = 'h104;
  localparam int CH_STRIDE  = 'h020;

  // field positions
  localparam int SRC_LSB    = 7;
  localparam int EXP_LSB    = 0;
  localparam int PRE_LSB    = 0;
  localparam int POL_BIT    = 8;
  localparam int ENT_LSB    = 16;
  localparam int ACT_LSB    = 0;
endpackage

// File: rtl/pwm_pair_regs.sv
`timescale 1ns/1ps
module pwm_pair_regs
  import pwm_pair_pkg::*;
#(
  parameter int NCH    = 4,
  parameter int NPAIR  = (NCH + 1) / 2,
  parameter int ADDR_W = 12
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [ADDR_W-1:0]           addr,
  input  logic [REG_W-1:0]            wdata,
  output logic [REG_W-1:0]            rdata,
  output logic [NPAIR-1:0][REG_W-1:0] cfg_q,
  output logic [REG_W-1:0]            gate_q,
  output logic [REG_W-1:0]            en_q,
  output logic [NCH-1:0][REG_W-1:0]   ctl_q,
  output logic [NCH-1:0][REG_W-1:0]   per_q,
  output logic [NCH-1:0]              restart,
  output logic [NPAIR-1:0]            div_clr
);

  logic [NPAIR-1:0]            hit_cfg;
  logic [NCH-1:0]              hit_ctl;
  logic [NCH-1:0]              hit_per;
  logic                        hit_gate;
  logic                        hit_en;
  logic [NPAIR-1:0][REG_W-1:0] cfg_d;
  logic [REG_W-1:0]            gate_d;
  logic [REG_W-1:0]            en_d;
  logic [NCH-1:0][REG_W-1:0]   ctl_d;
  logic [NCH-1:0][REG_W-1:0]   per_d;

  // address decode for writes
  always_comb begin
    for (int p = 0; p < NPAIR; p++)
      hit_cfg[p] = wr_en && (addr == ADDR_W'(CFG_BASE + CFG_STRIDE * p));
    for (int c = 0; c < NCH; c++) begin
      hit_ctl[c] = wr_en && (addr == ADDR_W'(CTL_BASE + CH_STRIDE * c));
      hit_per[c] = wr_en && (addr == ADDR_W'(PER_BASE + CH_STRIDE * c));
    end
    hit_gate = wr_en && (addr == ADDR_W'(GATE_ADDR));
    hit_en   = wr_en && (addr == ADDR_W'(EN_ADDR));
  end

  // next-state
  always_comb begin
    cfg_d  = cfg_q;
    gate_d = gate_q;
    en_d   = en_q;
    ctl_d  = ctl_q;
    per_d  = per_q;
    for (int p = 0; p < NPAIR; p++)
      if (hit_cfg[p]) cfg_d[p] = wdata;
    for (int c = 0; c < NCH; c++) begin
      if (hit_ctl[c]) ctl_d[c] = wdata;
      if (hit_per[c]) per_d[c] = wdata;
    end
    if (hit_gate) gate_d = wdata;
    if (hit_en)   en_d   = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      gate_q <= '0;
      en_q   <= '0;
      ctl_q  <= '0;
      per_q  <= '0;
    end else begin
      cfg_q  <= cfg_d;
      gate_q <= gate_d;
      en_q   <= en_d;
      ctl_q  <= ctl_d;
      per_q  <= per_d;
    end
  end

  assign restart = hit_ctl | hit_per;
  assign div_clr = hit_cfg;

  // read mux
  always_comb begin
    rdata = '0;
    for (int p = 0; p < NPAIR; p++)
      if (addr == ADDR_W'(CFG_BASE + CFG_STRIDE * p)) rdata = cfg_q[p];
    for (int c = 0; c < NCH; c++) begin
      if (addr == ADDR_W'(CTL_BASE + CH_STRIDE * c)) rdata = ctl_q[c];
      if (addr == ADDR_W'(PER_BASE + CH_STRIDE * c)) rdata = per_q[c];
    end
    if (addr == ADDR_W'(GATE_ADDR)) rdata = gate_q;
    if (addr == ADDR_W'(EN_ADDR))   rdata = en_q;
  end

endmodule

// File: rtl/pwm_pair_div.sv
`timescale 1ns/1ps
module pwm_pair_div
  import pwm_pair_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             osc_tick,
  input  logic             bus_tick,
  input  logic [1:0]       src_sel,
  input  logic [EXP_W-1:0] exp_m,
  input  logic             clr,
  output logic             tick
);

  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] cnt_d;
  logic [EXP_W-1:0] exp_eff;
  logic [DIV_W-1:0] mask;
  logic             src_tick;

  always_comb begin
    src_tick = (src_sel == 2'd0) ? osc_tick : bus_tick;
    exp_eff  = (exp_m > EXP_W'(MAX_EXP)) ? EXP_W'(MAX_EXP) : exp_m;
    mask     = DIV_W'(({1'b0, {DIV_W{1'b1}}}) >> (EXP_W'(MAX_EXP) - exp_eff));
    tick     = src_tick && ((cnt_q & mask) == mask);
    if (clr)           cnt_d = '0;
    else if (src_tick) cnt_d = cnt_q + DIV_W'(1);
    else               cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/pwm_pair_chan.sv
`timescale 1ns/1ps
module pwm_pair_chan
  import pwm_pair_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             run,
  input  logic             restart,
  input  logic [PRE_W-1:0] pre_k,
  input  logic [CNT_W-1:0] ent,
  input  logic [CNT_W-1:0] act,
  input  logic             act_high,
  output logic             lvl,
  output logic [CNT_W-1:0] cnt_o,
  output logic [PRE_W-1:0] pcnt_o
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [PRE_W-1:0] pcnt_q, pcnt_d;
  logic             in_active;

  always_comb begin
    cnt_d  = cnt_q;
    pcnt_d = pcnt_q;
    if (!run || restart) begin
      cnt_d  = '0;
      pcnt_d = '0;
    end else if (tick) begin
      if (pcnt_q >= pre_k) begin
        pcnt_d = '0;
        cnt_d  = (cnt_q >= ent) ? '0 : cnt_q + CNT_W'(1);
      end else begin
        pcnt_d = pcnt_q + PRE_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      pcnt_q <= '0;
    end else begin
      cnt_q  <= cnt_d;
      pcnt_q <= pcnt_d;
    end
  end

  // an active count beyond the period end saturates to fully active
  assign in_active = (act > ent) || (cnt_q < act);
  assign lvl       = act_high ? in_active : ~in_active;
  assign cnt_o     = cnt_q;
  assign pcnt_o    = pcnt_q;

endmodule

// File: rtl/pwm_pair_ctrl.sv
`timescale 1ns/1ps
module pwm_pair_ctrl
  import pwm_pair_pkg::*;
#(
  parameter int NCH    = 4,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              osc_tick,
  input  logic              bus_tick,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wdata,
  output logic [REG_W-1:0]  rdata,
  output logic [NCH-1:0]    pwm_lvl,
  output logic [NCH-1:0]    pwm_oe,
  output wire  [NCH-1:0]    pwm_pad
);

  localparam int NPAIR = (NCH + 1) / 2;

  logic [NPAIR-1:0][REG_W-1:0] cfg_q;
  logic [REG_W-1:0]            gate_q;
  logic [REG_W-1:0]            en_q;
  logic [NCH-1:0][REG_W-1:0]   ctl_q;
  logic [NCH-1:0][REG_W-1:0]   per_q;
  logic [NCH-1:0]              restart;
  logic [NPAIR-1:0]            div_clr;
  logic [NPAIR-1:0]            pair_tick;
  logic [NCH-1:0][CNT_W-1:0]   ch_cnt;
  logic [NCH-1:0][CNT_W-1:0]   ch_ent;
  logic [NCH-1:0][PRE_W-1:0]   ch_pcnt;
  logic [NCH-1:0][PRE_W-1:0]   ch_k;

  pwm_pair_regs #(
    .NCH    (NCH),
    .NPAIR  (NPAIR),
    .ADDR_W (ADDR_W)
  ) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .addr    (addr),
    .wdata   (wdata),
    .rdata   (rdata),
    .cfg_q   (cfg_q),
    .gate_q  (gate_q),
    .en_q    (en_q),
    .ctl_q   (ctl_q),
    .per_q   (per_q),
    .restart (restart),
    .div_clr (div_clr)
  );

  for (genvar p = 0; p < NPAIR; p++) begin : g_pair
    pwm_pair_div u_div (
      .clk      (clk),
      .rst_n    (rst_n),
      .osc_tick (osc_tick),
      .bus_tick (bus_tick),
      .src_sel  (cfg_q[p][SRC_LSB +: 2]),
      .exp_m    (cfg_q[p][EXP_LSB +: EXP_W]),
      .clr      (div_clr[p]),
      .tick     (pair_tick[p])
    );
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    assign ch_ent[c] = per_q[c][ENT_LSB +: CNT_W];
    assign ch_k[c]   = ctl_q[c][PRE_LSB +: PRE_W];
    assign pwm_oe[c] = gate_q[c] & en_q[c];

    pwm_pair_chan u_chan (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (pair_tick[c / 2]),
      .run      (pwm_oe[c]),
      .restart  (restart[c]),
      .pre_k    (ch_k[c]),
      .ent      (ch_ent[c]),
      .act      (per_q[c][ACT_LSB +: CNT_W]),
      .act_high (ctl_q[c][POL_BIT]),
      .lvl      (pwm_lvl[c]),
      .cnt_o    (ch_cnt[c]),
      .pcnt_o   (ch_pcnt[c])
    );

    assign pwm_pad[c] = pwm_oe[c] ? pwm_lvl[c] : 1'bz;
  end

endmodule

// File: rtl/pwm_pair_chk.sv
`timescale 1ns/1ps
module pwm_pair_chk
  import pwm_pair_pkg::*;
#(
  parameter int NCH = 4
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      wr_en,
  input logic [NCH-1:0]            pwm_oe,
  input logic [NCH-1:0]            pwm_lvl,
  input logic [NCH-1:0][CNT_W-1:0] ch_cnt,
  input logic [NCH-1:0][CNT_W-1:0] ch_ent,
  input logic [NCH-1:0][PRE_W-1:0] ch_pcnt,
  input logic [NCH-1:0][PRE_W-1:0] ch_k
);

  // R1: outputs come out of reset disabled
  a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (pwm_oe == '0));

  for (genvar c = 0; c < NCH; c++) begin : g_chk
    // R3: a channel can only start through a register write
    a_r3_start_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pwm_oe[c]) |-> $past(wr_en));

    // R3: an idle channel holds its level unless reprogrammed
    a_r3_idle_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (!pwm_oe[c] && !$past(wr_en)) |-> $stable(pwm_lvl[c]));

    // R10: period counter never passes the period end
    a_r10_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      ch_cnt[c] <= ch_ent[c]);

    // R10: prescaler never passes its limit
    a_r10_pre_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      ch_pcnt[c] <= ch_k[c]);
  end

endmodule

bind pwm_pair_ctrl pwm_pair_chk #(.NCH(NCH)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .wr_en   (wr_en),
  .pwm_oe  (pwm_oe),
  .pwm_lvl (pwm_lvl),
  .ch_cnt  (ch_cnt),
  .ch_ent  (ch_ent),
  .ch_pcnt (ch_pcnt),
  .ch_k    (ch_k)
);

// File: tb/test_pwm_pair_ctrl.sv
`timescale 1ns/1ps
module test_pwm_pair_ctrl;
  localparam int NCH    = 4;
  localparam int ADDR_W = 12;
  localparam int WINDOW = 3;

  logic              clk;
  logic              rst_n;
  logic              osc_tick;
  logic              bus_tick;
  logic              wr_en;
  logic [ADDR_W-1:0] addr;
  logic [31:0]       wdata;
  logic [31:0]       rdata;
  logic [NCH-1:0]    pwm_lvl;
  logic [NCH-1:0]    pwm_oe;
  wire  [NCH-1:0]    pwm_pad;

  int errs = 0;
  int nchk = 0;

  pwm_pair_ctrl #(.NCH(NCH), .ADDR_W(ADDR_W)) i_pwm_pair_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .osc_tick (osc_tick),
    .bus_tick (bus_tick),
    .wr_en    (wr_en),
    .addr     (addr),
    .wdata    (wdata),
    .rdata    (rdata),
    .pwm_lvl  (pwm_lvl),
    .pwm_oe   (pwm_oe),
    .pwm_pad  (pwm_pad)
  );

  initial begin
    clk = 1'b0;
    forever #5 clk = ~clk;
  end

  // bus strobe: high every second cycle
  initial begin
    bus_tick = 1'b0;
    forever begin
      @(negedge clk);
      bus_tick = ~bus_tick;
    end
  end

  typedef struct packed {
    logic [1:0]  ch;
    logic [1:0]  src;
    logic [3:0]  m;
    logic [7:0]  k;
    logic        pol;
    logic [15:0] ent;
    logic [15:0] act;
    logic [15:0] per;   // expected period in clk cycles
    logic [15:0] hi;    // expected high cycles of pwm_lvl per period
    logic        rise;  // expected rising edges per period
  } vec_t;

  localparam int NV = 9;
  localparam vec_t TBL [NV] = '{
    '{2'd0, 2'd0, 4'd0,  8'd0, 1'b1, 16'd9, 16'd3, 16'd10,  16'd3,   1'b1}, // R4
    '{2'd1, 2'd0, 4'd1,  8'd2, 1'b1, 16'd4, 16'd2, 16'd30,  16'd12,  1'b1}, // R8 odd channel of pair 0
    '{2'd2, 2'd1, 4'd0,  8'd1, 1'b1, 16'd3, 16'd1, 16'd16,  16'd4,   1'b1}, // R4 bus source
    '{2'd3, 2'd2, 4'd2,  8'd0, 1'b0, 16'd2, 16'd1, 16'd24,  16'd16,  1'b1}, // R5 inverted
    '{2'd0, 2'd0, 4'd0,  8'd0, 1'b1, 16'd5, 16'd9, 16'd6,   16'd6,   1'b0}, // R6 A > E
    '{2'd1, 2'd0, 4'd0,  8'd3, 1'b1, 16'd7, 16'd0, 16'd32,  16'd0,   1'b0}, // R6 A = 0
    '{2'd0, 2'd0, 4'd0,  8'd0, 1'b1, 16'd3, 16'd4, 16'd4,   16'd4,   1'b0}, // R6 A = E+1
    '{2'd2, 2'd0, 4'd12, 8'd0, 1'b1, 16'd1, 16'd1, 16'd512, 16'd256, 1'b1}, // R7 exponent clamp
    '{2'd3, 2'd0, 4'd0,  8'd0, 1'b0, 16'd9, 16'd0, 16'd10,  16'd10,  1'b0}  // R5 inverted, never active
  };

  function automatic string vec_tag(input int v);
    case (v)
      1:       return "R8";
      3, 8:    return "R5";
      4, 5, 6: return "R6";
      7:       return "R7";
      default: return "R4";
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1;
    addr  = ADDR_W'(a);
    wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_check(input int a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    addr = ADDR_W'(a);
    #1;
    check(rdata === exp, tag, $sformatf("read 0x%0h", a), rdata, exp);
  endtask

  initial begin
    #1_000_000;
    errs++;
    nchk++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errs, nchk);
    $finish;
  end

  initial begin
    osc_tick = 1'b1;
    wr_en    = 1'b0;
    addr     = '0;
    wdata    = '0;
    rst_n    = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    check(pwm_oe == '0, "R1", "oe after reset", pwm_oe, 0);
    rd_check('h020, 32'h0, "R1");
    rd_check('h104, 32'h0, "R1");
    rd_check('h080, 32'h0, "R1");

    // R2: readback
    wr('h124, 32'hABCD_1234);
    wr('h024, 32'h0000_0183);
    wr('h040, 32'h000F_0000);
    wr('h160, 32'h0000_01FE);
    rd_check('h124, 32'hABCD_1234, "R2");
    rd_check('h024, 32'h0000_0183, "R2");
    rd_check('h040, 32'h000F_0000, "R2");
    rd_check('h160, 32'h0000_01FE, "R2");

    // R3: both permissions needed
    wr('h020, 32'h0);
    wr('h100, 32'h0000_0100);
    wr('h104, {16'd9, 16'd3});
    wr('h040, 32'h1);
    wr('h080, 32'h0);
    check(pwm_oe[0] == 1'b0, "R3", "gate only", pwm_oe[0], 0);
    wr('h040, 32'h0);
    wr('h080, 32'h1);
    check(pwm_oe[0] == 1'b0, "R3", "enable only", pwm_oe[0], 0);
    wr('h040, 32'h1);
    check(pwm_oe[0] == 1'b1, "R3", "gate and enable", pwm_oe[0], 1);
    check(pwm_pad[0] === pwm_lvl[0], "R3", "pad follows level", pwm_pad[0], pwm_lvl[0]);
    wr('h080, 32'h0);
    check(pwm_oe[0] == 1'b0, "R3", "disable drops oe", pwm_oe[0], 0);

    // table of waveform vectors
    for (int v = 0; v < NV; v++) begin
      vec_t t;
      int   hi;
      int   rs;
      logic prev;
      logic s;
      t = TBL[v];
      wr('h080, 32'h0);
      wr('h020 + 4 * (int'(t.ch) >> 1), {23'd0, t.src, 3'd0, t.m});
      wr('h100 + 'h20 * int'(t.ch), {23'd0, t.pol, t.k});
      wr('h104 + 'h20 * int'(t.ch), {t.ent, t.act});
      wr('h040, 32'(1) << t.ch);
      wr('h080, 32'(1) << t.ch);
      repeat (int'(t.per)) @(negedge clk);
      prev = pwm_lvl[t.ch];
      hi = 0;
      rs = 0;
      for (int c = 0; c < WINDOW * int'(t.per); c++) begin
        @(negedge clk);
        s = pwm_lvl[t.ch];
        if (s) hi++;
        if (s && !prev) rs++;
        prev = s;
      end
      check(pwm_oe == (NCH'(1) << t.ch), vec_tag(v), $sformatf("vec %0d oe", v),
            pwm_oe, NCH'(1) << t.ch);
      check(hi == WINDOW * int'(t.hi), vec_tag(v), $sformatf("vec %0d high cycles", v),
            hi, WINDOW * int'(t.hi));
      check(rs == WINDOW * int'(t.rise), vec_tag(v), $sformatf("vec %0d rising edges", v),
            rs, WINDOW * int'(t.rise));
    end

    // R9 and R10: write mid-period restarts the counter at once, then wraps after E
    wr('h080, 32'h0);
    wr('h020, 32'h0);
    wr('h100, 32'h0000_0100);
    wr('h104, {16'd99, 16'd50});
    wr('h040, 32'h1);
    wr('h080, 32'h1);
    repeat (70) @(negedge clk);
    begin
      logic [10:0] seen;
      logic [10:0] want;
      want = 11'b100_0000_0111; // bit i = sample i: 3 high, 7 low, high again
      wr('h104, {16'd9, 16'd3});
      seen[0] = pwm_lvl[0];
      for (int i = 1; i < 11; i++) begin
        @(negedge clk);
        seen[i] = pwm_lvl[0];
      end
      check(seen[2:0] == want[2:0], "R9", "active phase right after write", seen, want);
      check(seen == want, "R10", "wrap after E", seen, want);
    end

    // R1: asynchronous reset while running
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check(pwm_oe == '0, "R1", "oe during async reset", pwm_oe, 0);
    @(negedge clk);
    rst_n = 1'b1;
    rd_check('h104, 32'h0, "R1");

    $display("Result: errors=%0d of %0d checks", errs, nchk);
    $finish;
  end

endmodule